// File: doc/BRIEF.md
# Waveform Parameter Sweep Controller

This block moves one waveform parameter (a frequency tuning word, an amplitude, an offset or a phase word) between a lower and an upper bound in equal steps. Software programs the two bounds, how many steps the rising leg takes and how many the falling leg takes, a prescale ratio for the step tick, and whether the sweep runs once or repeats. A command then starts the sweep in one of four shapes: rising only, falling only, rising then falling, or falling then rising. A stop command freezes the sweep where it stands.

The step size of each leg is the integer quotient of the span by that leg's step count. It is computed by two sequential dividers when the sweep starts. The last step of a leg always lands exactly on the bound, so truncation never accumulates. Bounds, step counts and the repeat flag are captured when the start command is accepted. The lower bound is assumed not to exceed the upper bound.

Top module: `param_sweep`

## Requirements
- R1: After reset `param_out` is 0 and `busy` is 0.
- R2: A start command is `cmd_valid` high with `cmd_op` = 1 (rise), 2 (fall), 3 (rise then fall) or 4 (fall then rise). On the next cycle `busy` is 1 and `param_out` holds the start value: the lower bound for codes 1 and 3, the upper bound for codes 2 and 4. Step ticks in the first VAL_W+2 cycles after the command are ignored. A start during a running sweep restarts it.
- R3: A rising step adds floor((hi−lo)/N) and a falling step subtracts it, where N is that leg's step count. The final step of a leg sets the output exactly to the bound.
- R4: The rising leg uses `up_steps` and the falling leg uses `down_steps`. A count of 0 acts as 1.
- R5: One step is taken per `step_div`+1 accepted `step_tick` pulses. Apart from a step, a start or a stop, `param_out` does not change.
- R6: With `repeat_en` = 0, `busy` drops on the cycle after the final step and the output holds the final value (the end bound for codes 1 and 2, the start bound for codes 3 and 4).
- R7: With `repeat_en` = 1 and a one-direction sweep, the step after the end bound returns the output to the start bound and the sweep repeats.
- R8: With `repeat_en` = 1 and a two-leg sweep, the legs alternate indefinitely with no jump; each bound is reached once per turn-around.
- R9: `cmd_op` = 5 (stop) clears `busy` on the next cycle and freezes the output; later ticks have no effect.
- R10: A start command issued while both bounds are zero is ignored: `busy` and `param_out` keep their values.
- R11: `cmd_op` values 0, 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_bound | input | VAL_W | Lower sweep bound |
| hi_bound | input | VAL_W | Upper sweep bound |
| up_steps | input | STEP_W | Steps in the rising leg |
| down_steps | input | STEP_W | Steps in the falling leg |
| step_div | input | PRE_W | Step tick prescale, ratio is value+1 |
| repeat_en | input | 1 | 1 = continuous, 0 = single shot |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| step_tick | input | 1 | Step tick pulse |
| param_out | output | VAL_W | Current parameter value |
| busy | output | 1 | Sweep in progress |

## Verification
Directed sweeps cover each start shape in both single and repeat modes. Spans that do not divide evenly show whether the last step is forced onto the bound instead of drifting. A zero step count and a prescale ratio of three separate the leg count and the tick-counting paths. Stop, zero bounds, unused codes and a restart during a run each probe one override, and seeded random sweeps over shapes, spans, counts and ratios are compared step by step against a closed-form model of the output at every tick.

// File: rtl/sweep_pkg.sv
// Package: command codes and controller states shared by the sweep blocks.
// Assumes: a 3-bit command field; codes not listed are treated as no-ops.
package sweep_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_UP     = 3'd1,
        OP_DOWN   = 3'd2,
        OP_UPDOWN = 3'd3,
        OP_DOWNUP = 3'd4,
        OP_STOP   = 3'd5
    } sweep_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2
    } sweep_st_e;
endpackage

// File: rtl/sweep_div.sv
// Module: sweep_div
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes: divisor is never zero; operands are captured on start;
// done is high when idle and low for exactly W cycles after start.
module sweep_div #(
    parameter int W  = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic [W-1:0]  quot,
    output logic          done
);
    localparam int CNT_W = $clog2(W + 1);
    localparam int MW    = W + DW;

    logic [CNT_W-1:0] cnt_q;
    logic [DW:0]      rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvd_q;
    logic [DW-1:0]    dsr_q;
    logic [DW:0]      shifted;
    logic             fits;

    // trial subtraction for the current quotient bit
    always_comb begin
        shifted = {rem_q[DW-1:0], quo_q[W-1]};
        fits    = shifted >= {1'b0, dsr_q};
    end

    // operand capture and iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            dvd_q <= '0;
            dsr_q <= {{(DW-1){1'b0}}, 1'b1};
        end else if (start) begin
            cnt_q <= CNT_W'(W);
            rem_q <= '0;
            quo_q <= dividend;
            dvd_q <= dividend;
            dsr_q <= divisor;
        end else if (cnt_q != '0) begin
            rem_q <= fits ? (shifted - {1'b0, dsr_q}) : shifted;
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quot = quo_q;
    assign done = (cnt_q == '0);

    // R2
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R3
    div_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |->
            ((MW'(quo_q) * MW'(dsr_q) <= MW'(dvd_q)) &&
             (MW'(quo_q) * MW'(dsr_q) + MW'(dsr_q) > MW'(dvd_q))));
endmodule

// File: rtl/sweep_prescale.sv
// Module: sweep_prescale
// Passes one of every div+1 tick pulses on as a step advance.
// Assumes: clear is held whenever steps must not be taken; clearing
// restarts the count so the first step needs a full div+1 ticks.
module sweep_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [PW-1:0] div,
    output logic          adv
);
    logic [PW-1:0] cnt_q;
    logic          wrap;

    // terminal count reached on this tick
    always_comb wrap = (cnt_q >= div);

    // tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign adv = tick && !clear && wrap;

    // R5
    adv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && $past(adv)) |-> (div == '0));
endmodule

// File: rtl/param_sweep.sv
// Module: param_sweep (top)
// Steps one waveform parameter between two bounds in four sweep shapes,
// single shot or repeating, one step per prescaled tick.
// Assumes: lo_bound <= hi_bound; configuration is captured at start;
// a start with both bounds zero is refused.
module param_sweep
    import sweep_pkg::*;
#(
    parameter int VAL_W  = 32,
    parameter int STEP_W = 16,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  lo_bound,
    input  logic [VAL_W-1:0]  hi_bound,
    input  logic [STEP_W-1:0] up_steps,
    input  logic [STEP_W-1:0] down_steps,
    input  logic [PRE_W-1:0]  step_div,
    input  logic              repeat_en,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              step_tick,
    output logic [VAL_W-1:0]  param_out,
    output logic              busy
);
    localparam int NLEG = 2;
    localparam logic [STEP_W-1:0] ONE_STEP = {{(STEP_W-1){1'b0}}, 1'b1};

    sweep_st_e         st_q;
    logic [VAL_W-1:0]  val_q, lo_q, hi_q;
    logic [STEP_W-1:0] nu_q, nd_q, k_q;
    logic              dir_up_q, two_leg_q, second_q, cont_q;

    logic              is_start_op, bounds_zero, start_acc, stop_cmd, adv;
    logic [VAL_W-1:0]  span;
    logic [STEP_W-1:0] leg_steps [NLEG];
    logic [VAL_W-1:0]  leg_inc   [NLEG];
    logic [NLEG-1:0]   leg_done;

    logic [STEP_W-1:0] cur_n, k_nxt;
    logic [VAL_W-1:0]  cur_inc, cur_end, cur_start;

    // command decode and operand preparation
    always_comb begin
        is_start_op  = (cmd_op == OP_UP) || (cmd_op == OP_DOWN) ||
                       (cmd_op == OP_UPDOWN) || (cmd_op == OP_DOWNUP);
        bounds_zero  = (lo_bound == '0) && (hi_bound == '0);
        start_acc    = cmd_valid && is_start_op && !bounds_zero;
        stop_cmd     = cmd_valid && (cmd_op == OP_STOP);
        span         = hi_bound - lo_bound;
        leg_steps[0] = (up_steps == '0)   ? ONE_STEP : up_steps;
        leg_steps[1] = (down_steps == '0) ? ONE_STEP : down_steps;
    end

    // one step-size divider per leg direction
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        sweep_div #(.W(VAL_W), .DW(STEP_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start_acc),
            .dividend (span),
            .divisor  (leg_steps[g]),
            .quot     (leg_inc[g]),
            .done     (leg_done[g])
        );
    end

    // step tick prescaler, held clear outside the run state
    sweep_prescale #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_q != ST_RUN),
        .tick  (step_tick),
        .div   (step_div),
        .adv   (adv)
    );

    // parameters of the leg in progress
    always_comb begin
        cur_n     = dir_up_q ? nu_q : nd_q;
        cur_inc   = dir_up_q ? leg_inc[0] : leg_inc[1];
        cur_end   = dir_up_q ? hi_q : lo_q;
        cur_start = dir_up_q ? lo_q : hi_q;
        k_nxt     = k_q + 1'b1;
    end

    // sweep sequencer: command handling and per-step update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            val_q     <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            nu_q      <= ONE_STEP;
            nd_q      <= ONE_STEP;
            k_q       <= '0;
            dir_up_q  <= 1'b1;
            two_leg_q <= 1'b0;
            second_q  <= 1'b0;
            cont_q    <= 1'b0;
        end else if (stop_cmd) begin
            st_q <= ST_IDLE;
        end else if (start_acc) begin
            st_q      <= ST_PREP;
            lo_q      <= lo_bound;
            hi_q      <= hi_bound;
            nu_q      <= leg_steps[0];
            nd_q      <= leg_steps[1];
            cont_q    <= repeat_en;
            two_leg_q <= (cmd_op == OP_UPDOWN) || (cmd_op == OP_DOWNUP);
            dir_up_q  <= (cmd_op == OP_UP) || (cmd_op == OP_UPDOWN);
            second_q  <= 1'b0;
            k_q       <= '0;
            val_q     <= ((cmd_op == OP_UP) || (cmd_op == OP_UPDOWN)) ?
                         lo_bound : hi_bound;
        end else begin
            case (st_q)
                ST_PREP: if (&leg_done) st_q <= ST_RUN;
                ST_RUN: if (adv) begin
                    if (!two_leg_q && (k_q == cur_n)) begin
                        val_q <= cur_start;
                        k_q   <= '0;
                    end else if (k_nxt == cur_n) begin
                        val_q <= cur_end;
                        if (two_leg_q && !second_q) begin
                            dir_up_q <= !dir_up_q;
                            second_q <= 1'b1;
                            k_q      <= '0;
                        end else if (!cont_q) begin
                            st_q <= ST_IDLE;
                            k_q  <= k_nxt;
                        end else if (two_leg_q) begin
                            dir_up_q <= !dir_up_q;
                            second_q <= 1'b0;
                            k_q      <= '0;
                        end else begin
                            k_q <= k_nxt;
                        end
                    end else begin
                        val_q <= dir_up_q ? (val_q + cur_inc) : (val_q - cur_inc);
                        k_q   <= k_nxt;
                    end
                end
                default: ;
            endcase
        end
    end

    assign param_out = val_q;
    assign busy      = (st_q != ST_IDLE);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !busy);

    // R10
    zero_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_start_op && bounds_zero && !busy) |=>
            (!busy && $stable(param_out)));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> busy);

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(stop_cmd || adv));

    // R5
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cmd_valid) |=> $stable(param_out));
endmodule

// File: tb/sim_param_sweep.sv
module sim_param_sweep;
    localparam int VW = 32;
    localparam int SW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] lo_bound = '0, hi_bound = '0;
    logic [SW-1:0] up_steps = '0, down_steps = '0;
    logic [PW-1:0] step_div = '0;
    logic          repeat_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic          step_tick = 1'b0;
    logic [VW-1:0] param_out;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit fin = 1'b0;

    int m_mode, m_lo, m_hi, m_nu, m_nd, m_div, m_ticks;
    bit m_cont;

    always #10 clk = ~clk;

    param_sweep #(.VAL_W(VW), .STEP_W(SW), .PRE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .lo_bound(lo_bound), .hi_bound(hi_bound),
        .up_steps(up_steps), .down_steps(down_steps), .step_div(step_div),
        .repeat_en(repeat_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .step_tick(step_tick), .param_out(param_out), .busy(busy)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int upv(int j, int nu, int qu);
        return (j >= nu) ? m_hi : m_lo + j * qu;
    endfunction

    function automatic int dnv(int j, int nd, int qd);
        return (j >= nd) ? m_lo : m_hi - j * qd;
    endfunction

    function automatic int total_steps();
        int nu = (m_nu == 0) ? 1 : m_nu;
        int nd = (m_nd == 0) ? 1 : m_nd;
        if (m_mode == 1) return nu;
        if (m_mode == 2) return nd;
        return nu + nd;
    endfunction

    function automatic int model_val(int s);
        int nu = (m_nu == 0) ? 1 : m_nu;
        int nd = (m_nd == 0) ? 1 : m_nd;
        int qu = (m_hi - m_lo) / nu;
        int qd = (m_hi - m_lo) / nd;
        int tot = nu + nd;
        int p;
        case (m_mode)
            1: begin
                if (!m_cont) return upv((s > nu) ? nu : s, nu, qu);
                return upv(s % (nu + 1), nu, qu);
            end
            2: begin
                if (!m_cont) return dnv((s > nd) ? nd : s, nd, qd);
                return dnv(s % (nd + 1), nd, qd);
            end
            3: begin
                if (!m_cont && s >= tot) return m_lo;
                p = s % tot;
                return (p < nu) ? upv(p, nu, qu) : dnv(p - nu, nd, qd);
            end
            default: begin
                if (!m_cont && s >= tot) return m_hi;
                p = s % tot;
                return (p < nd) ? dnv(p, nd, qd) : upv(p - nd, nu, qu);
            end
        endcase
    endfunction

    function automatic bit model_busy(int s);
        return !(!m_cont && s >= total_steps());
    endfunction

    task automatic send_cmd(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = '0;
    endtask

    // starts a sweep, checks the start value and the ignored prep-window tick
    task automatic start_sweep(input int mode, input int lo, input int hi,
                               input int nu, input int nd, input bit cont,
                               input int dv);
        m_mode = mode; m_lo = lo; m_hi = hi; m_nu = nu; m_nd = nd;
        m_cont = cont; m_div = dv; m_ticks = 0;
        @(negedge clk);
        lo_bound = VW'(lo); hi_bound = VW'(hi);
        up_steps = SW'(nu); down_steps = SW'(nd);
        repeat_en = cont; step_div = PW'(dv);
        send_cmd(3'(mode));
        check("R2 start value", param_out, model_val(0));
        check("R2 busy on start", busy, 1);
        step_tick = 1'b1;
        @(negedge clk);
        step_tick = 1'b0;
        check("R2 prep tick ignored", param_out, model_val(0));
        repeat (VW + 2) @(negedge clk);
    endtask

    task automatic tick_check(input string req);
        int s;
        step_tick = 1'b1;
        @(negedge clk);
        step_tick = 1'b0;
        m_ticks++;
        s = m_ticks / (m_div + 1);
        check(req, param_out, model_val(s));
        check({req, " busy"}, busy, model_busy(s));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 value", param_out, 0);
        check("R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 value after release", param_out, 0);

        // R3 R6: rising single, uneven span (100,133,166,200)
        start_sweep(1, 100, 200, 3, 5, 0, 0);
        for (int i = 0; i < 5; i++) tick_check("R3 R6 rise single");
        check("R6 holds end", param_out, 200);

        // R7: falling repeat, wraps to the upper bound
        start_sweep(2, 10, 50, 7, 4, 1, 0);
        for (int i = 0; i < 12; i++) tick_check("R7 fall repeat");

        // R8 R4: rise-fall repeat, different leg counts
        start_sweep(3, 0, 30, 2, 3, 1, 0);
        for (int i = 0; i < 15; i++) tick_check("R8 R4 rise-fall repeat");

        // R4 R6: fall-rise single, zero rising count acts as one
        start_sweep(4, 1000, 1999, 0, 2, 0, 0);
        for (int i = 0; i < 5; i++) tick_check("R4 R6 fall-rise single");

        // R5: three ticks per step
        start_sweep(1, 5, 905, 4, 1, 0, 2);
        for (int i = 0; i < 14; i++) tick_check("R5 prescale");

        // R2: restart while running
        start_sweep(1, 0, 400, 8, 1, 1, 0);
        for (int i = 0; i < 3; i++) tick_check("R2 before restart");
        start_sweep(2, 0, 400, 8, 4, 0, 0);
        for (int i = 0; i < 5; i++) tick_check("R2 after restart");

        // R11: unused codes during a run
        start_sweep(1, 0, 90, 9, 1, 1, 0);
        for (int i = 0; i < 2; i++) tick_check("R11 before");
        send_cmd(3'd0); send_cmd(3'd6); send_cmd(3'd7);
        check("R11 value kept", param_out, model_val(m_ticks));
        check("R11 busy kept", busy, 1);
        for (int i = 0; i < 3; i++) tick_check("R11 after");

        // R9: stop mid-sweep
        send_cmd(3'd5);
        held = model_val(m_ticks);
        check("R9 busy cleared", busy, 0);
        check("R9 value frozen", param_out, held);
        for (int i = 0; i < 3; i++) begin
            step_tick = 1'b1; @(negedge clk); step_tick = 1'b0; @(negedge clk);
        end
        check("R9 ticks ignored", param_out, held);

        // R10: both bounds zero refuses the start
        @(negedge clk);
        lo_bound = '0; hi_bound = '0;
        send_cmd(3'd1);
        check("R10 busy unchanged", busy, 0);
        check("R10 value unchanged", param_out, held);
        step_tick = 1'b1; @(negedge clk); step_tick = 1'b0;
        repeat (VW + 4) @(negedge clk);
        check("R10 value after ticks", param_out, held);

        // random sweeps against the model
        for (int r = 0; r < 30; r++) begin
            int lo = int'($urandom_range(0, 30000));
            int hi = lo + int'($urandom_range(0, 30000));
            int n;
            if (hi == 0) hi = 1;
            start_sweep(int'($urandom_range(1, 4)), lo, hi,
                        int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                        bit'($urandom_range(0, 1)), int'($urandom_range(0, 2)));
            n = int'($urandom_range(1, (total_steps() * 2 + 2) * (m_div + 1)));
            for (int i = 0; i < n; i++) tick_check("R3 R7 R8 random");
            send_cmd(3'd5);
            check("R9 random stop", busy, 0);
        end

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule